// File: doc/BRIEF.md
# Timer Trigger Generator

This block is a compact up-counting timer. Its main purpose is to drive one synchronisation line, `trgo`, that other timers on the chip can follow. A three-bit master-mode field picks what appears on that line. The choices are a pulse on restart, the counter's run state, the wrap/update event, a compare or capture pulse, or one of the two compare reference levels. The counter runs from zero up to a reload limit and then returns to zero. Two compare channels each drive a reference level that is high while the count is below the channel's threshold.

A small slave controller reacts to a trigger level. That trigger comes either from the channel-0 trigger input or from a dedicated external pin. The channel-0 trigger input is the channel-0 pin itself, or the exclusive-OR of all three channel pins, which suits hall-effect rotor sensing. The slave controller can restart the counter on a rising trigger edge. It can let the counter advance only while the trigger is high. It can also set the run bit by hardware when the trigger rises.

Software writes four word locations through a simple write strobe:
- Address 0 is the control word.
- Address 1 holds the reload limit.
- Address 2 holds the channel-0 threshold.
- Address 3 holds the channel-1 threshold.

Threshold and limit writes take effect at the clock edge that stores them.

Top module: `tmr_trgo_gen`

## Requirements
- R1: Control word fields: bit 0 is run and bit 5 is the XOR select. When bit 5 is 0, the channel-0 trigger input equals `ch_in[0]`; when bit 5 is 1, it equals `ch_in[0]^ch_in[1]^ch_in[2]`. Bit 8 is the trigger source: 0 takes the channel-0 trigger input as the slave trigger, 1 takes `ext_trig`.
- R2: When counting is allowed, the counter steps by one each clock. When it equals the limit (address 1), it returns to 0 on the next clock and raises a one-cycle update event. With master mode (control bits 4:2) 010, `trgo` is high in the cycle after each update event.
- R3: Writing the control word with bit 1 set restarts the counter at 0 and raises an update event. If the master mode already held 000, `trgo` is high for exactly the one cycle after the write. Counter wraps do not pulse `trgo` in mode 000.
- R4: In slave mode 01 (control bits 7:6), a rising slave trigger restarts the counter at 0. In master mode 000, `trgo` pulses two cycles after the trigger rises, one cycle later than the update pulse seen in mode 010.
- R5: In master mode 001, `trgo` shows the effective count enable. With the master-slave bit (control bit 9) clear, it lags that enable by two clocks. With bit 9 set, it lags by one clock.
- R6: In slave mode 10, the counter advances only while the run bit is set and the slave trigger is high.
- R7: In slave mode 11, a rising slave trigger sets the run bit by hardware.
- R8: `oc_ref[i]` is 1 exactly when the counter is below the channel-i threshold (address 2 for channel 0, address 3 for channel 1).
- R9: In master mode 011, `trgo` pulses for one cycle after each compare match made while counting. When control bit 10 is set, channel 0 stops matching and instead pulses on each rising edge of the channel-0 trigger input, whether or not the counter runs.
- R10: In master modes 100 and 101, `trgo` equals `oc_ref[0]` and `oc_ref[1]` respectively.
- R11: In master modes 110 and 111, `trgo` stays 0.
- R12: After reset, every register is zero, the counter is stopped, and `trgo` and `oc_ref` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word select: 0 control, 1 limit, 2 threshold 0, 3 threshold 1 |
| wr_data | input | CNT_W | Write data |
| ch_in | input | 3 | Channel input pins |
| ext_trig | input | 1 | External trigger pin |
| trgo | output | 1 | Synchronisation trigger output |
| oc_ref | output | 2 | Compare reference levels, one per channel |

## Verification
On every cycle, the assertions check several invariants:
- the reference levels against the live count and thresholds;
- the wrap and restart to zero after a limit hit, a software restart or a slave restart;
- the hardware-set run bit in trigger-start mode;
- the copy of the reference levels in modes 100/101;
- the silence of modes 110/111.

Only the directed scenarios can show the cycle counts between a pin change and `trgo`. These include the two-clock versus one-clock lag in mode 001, the extra delay on slave restarts in mode 000, and the XOR selection of the channel pins. The scenarios also cover pulse rates over whole counter periods and the gating in pause mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // master-mode selector values
    typedef enum logic [2:0] {
        MM_RESET   = 3'd0,
        MM_ENABLE  = 3'd1,
        MM_UPDATE  = 3'd2,
        MM_CCPULSE = 3'd3,
        MM_REF0    = 3'd4,
        MM_REF1    = 3'd5,
        MM_LOW6    = 3'd6,
        MM_LOW7    = 3'd7
    } mm_e;

    // slave controller modes
    typedef enum logic [1:0] {
        SLV_OFF   = 2'd0,
        SLV_RESET = 2'd1,
        SLV_PAUSE = 2'd2,
        SLV_START = 2'd3
    } slv_e;

    // control word bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_UG   = 1;
    localparam int CTL_MM   = 2;
    localparam int CTL_TXOR = 5;
    localparam int CTL_SLV  = 6;
    localparam int CTL_TSRC = 8;
    localparam int CTL_MSM  = 9;
    localparam int CTL_CAP0 = 10;
    localparam int CTL_BITS = 11;

    // word addresses
    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_ARR  = 2'd1;
    localparam logic [1:0] A_CMP0 = 2'd2;
    localparam logic [1:0] A_CMP1 = 2'd3;

    localparam int NPIN   = 3;
    localparam int CMP_CH = 2;

    typedef struct packed {
        logic run;
        mm_e  mm;
        logic txor;
        slv_e slv;
        logic tsrc;
        logic msm;
        logic cap0;
    } ctl_t;

endpackage

// File: rtl/tmr_trig_in.sv
module tmr_trig_in
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] ch_in,
    input  logic            ext_trig,
    input  logic            txor,
    input  logic            tsrc,
    output logic            trig,
    output logic            trig_rise,
    output logic            ti0_rise
);

    typedef struct packed {
        logic ti0_prev;
        logic trig_prev;
    } tin_s;

    tin_s s_d, s_q;
    logic ti0;

    always_comb begin
        ti0       = txor ? (^ch_in) : ch_in[0];
        trig      = tsrc ? ext_trig : ti0;
        ti0_rise  = ti0 & ~s_q.ti0_prev;
        trig_rise = trig & ~s_q.trig_prev;
        s_d           = s_q;
        s_d.ti0_prev  = ti0;
        s_d.trig_prev = trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  slv_e             slv,
    input  logic             trig,
    input  logic             trig_rise,
    input  logic             sw_ug,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             en_eff,
    output logic             upd_ev,
    output logic             slv_rst,
    output logic             start_set
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_s;

    core_s s_d, s_q;
    logic  restart;
    logic  at_top;

    always_comb begin
        slv_rst   = (slv == SLV_RESET) && trig_rise;
        start_set = (slv == SLV_START) && trig_rise;
        en_eff    = run && ((slv != SLV_PAUSE) || trig);
        restart   = sw_ug || slv_rst;
        at_top    = (s_q.cnt == arr);
        s_d       = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (en_eff) begin
            s_d.cnt = at_top ? '0 : s_q.cnt + 1'b1;
        end
        upd_ev  = restart || (en_eff && at_top);
        cnt     = s_q.cnt;
        cnt_nxt = s_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_cmp_ch.sv
module tmr_cmp_ch #(
    parameter int CNT_W = 16
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] thr_nxt,
    output logic             hit,
    output logic             lvl_nxt,
    output logic             lvl
);

    typedef struct packed {
        logic lvl;
    } ch_s;

    ch_s s_d, s_q;

    always_comb begin
        hit     = en && (cnt == thr);
        s_d     = s_q;
        s_d.lvl = (cnt_nxt < thr_nxt);
        lvl_nxt = s_d.lvl;
        lvl     = s_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_trgo_mux.sv
module tmr_trgo_mux
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mm_e               mm,
    input  logic              msm,
    input  logic              sw_ug,
    input  logic              slv_rst,
    input  logic              en_eff,
    input  logic              upd_ev,
    input  logic              cc_ev,
    input  logic [CMP_CH-1:0] lvl_nxt,
    output logic              trgo
);

    typedef struct packed {
        logic rst_dly;
        logic en_dly;
        logic trgo;
    } mux_s;

    mux_s s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rst_dly = slv_rst;
        s_d.en_dly  = en_eff;
        unique case (mm)
            MM_RESET:   s_d.trgo = sw_ug || s_q.rst_dly;
            MM_ENABLE:  s_d.trgo = msm ? en_eff : s_q.en_dly;
            MM_UPDATE:  s_d.trgo = upd_ev;
            MM_CCPULSE: s_d.trgo = cc_ev;
            MM_REF0:    s_d.trgo = lvl_nxt[0];
            MM_REF1:    s_d.trgo = lvl_nxt[1];
            default:    s_d.trgo = 1'b0;
        endcase
        trgo = s_q.trgo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_trgo_gen.sv
module tmr_trgo_gen
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16   // must be at least CTL_BITS wide
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NPIN-1:0]   ch_in,
    input  logic              ext_trig,
    output logic              trgo,
    output logic [CMP_CH-1:0] oc_ref
);

    localparam int NCH = CMP_CH;

    typedef struct packed {
        ctl_t                      ctl;
        logic [CNT_W-1:0]          arr;
        logic [NCH-1:0][CNT_W-1:0] cmp;
    } regs_s;

    regs_s            r_d, r_q;
    logic             sw_ug;
    logic             start_set;
    logic             trig, trig_rise, ti0_rise;
    logic             en_eff, upd_ev, slv_rst, cc_ev;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [NCH-1:0]   hit, lvl_nxt;

    // register file: next state
    always_comb begin
        r_d   = r_q;
        sw_ug = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTL: begin
                    r_d.ctl.run  = wr_data[CTL_RUN];
                    r_d.ctl.mm   = mm_e'(wr_data[CTL_MM +: 3]);
                    r_d.ctl.txor = wr_data[CTL_TXOR];
                    r_d.ctl.slv  = slv_e'(wr_data[CTL_SLV +: 2]);
                    r_d.ctl.tsrc = wr_data[CTL_TSRC];
                    r_d.ctl.msm  = wr_data[CTL_MSM];
                    r_d.ctl.cap0 = wr_data[CTL_CAP0];
                    sw_ug        = wr_data[CTL_UG];
                end
                A_ARR:   r_d.arr    = wr_data;
                A_CMP0:  r_d.cmp[0] = wr_data;
                A_CMP1:  r_d.cmp[1] = wr_data;
                default: ;
            endcase
        end
        if (start_set) r_d.ctl.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    tmr_trig_in u_tin (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_in     (ch_in),
        .ext_trig  (ext_trig),
        .txor      (r_q.ctl.txor),
        .tsrc      (r_q.ctl.tsrc),
        .trig      (trig),
        .trig_rise (trig_rise),
        .ti0_rise  (ti0_rise)
    );

    tmr_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (r_q.ctl.run),
        .slv       (r_q.ctl.slv),
        .trig      (trig),
        .trig_rise (trig_rise),
        .sw_ug     (sw_ug),
        .arr       (r_q.arr),
        .cnt       (cnt),
        .cnt_nxt   (cnt_nxt),
        .en_eff    (en_eff),
        .upd_ev    (upd_ev),
        .slv_rst   (slv_rst),
        .start_set (start_set)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_cmp_ch #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_eff),
            .cnt     (cnt),
            .cnt_nxt (cnt_nxt),
            .thr     (r_q.cmp[i]),
            .thr_nxt (r_d.cmp[i]),
            .hit     (hit[i]),
            .lvl_nxt (lvl_nxt[i]),
            .lvl     (oc_ref[i])
        );
    end

    // channel 0 becomes a capture source when selected
    always_comb begin
        cc_ev = (r_q.ctl.cap0 ? ti0_rise : hit[0]) || hit[1];
    end

    tmr_trgo_mux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .mm      (r_q.ctl.mm),
        .msm     (r_q.ctl.msm),
        .sw_ug   (sw_ug),
        .slv_rst (slv_rst),
        .en_eff  (en_eff),
        .upd_ev  (upd_ev),
        .cc_ev   (cc_ev),
        .lvl_nxt (lvl_nxt),
        .trgo    (trgo)
    );

endmodule

// File: rtl/tmr_trgo_gen_chk.sv
module tmr_trgo_gen_chk #(
    parameter int CNT_W = 16
)
(
    input logic             clk,
    input logic             rst_n,
    input logic             trgo,
    input logic [1:0]       oc_ref,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr,
    input logic [CNT_W-1:0] cmp0,
    input logic [CNT_W-1:0] cmp1,
    input logic [2:0]       mm,
    input logic [1:0]       slv,
    input logic             run,
    input logic             en_eff,
    input logic             sw_ug,
    input logic             slv_rst,
    input logic             trig_rise
);

    // R8
    ref0_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_ref[0] == (cnt < cmp0));

    // R8
    ref1_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_ref[1] == (cnt < cmp1));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && cnt == arr && !sw_ug && !slv_rst) |=> cnt == '0);

    // R3
    sw_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ug |=> cnt == '0);

    // R3
    sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ug && mm == 3'd0) |=> trgo);

    // R4
    slv_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_rst |=> cnt == '0);

    // R7
    hw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv == 2'd3 && trig_rise) |=> run);

    // R10
    ref0_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm == 3'd4) |=> trgo == oc_ref[0]);

    // R10
    ref1_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm == 3'd5) |=> trgo == oc_ref[1]);

    // R11
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm[2:1] == 2'b11) |=> !trgo);

endmodule

bind tmr_trgo_gen tmr_trgo_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trgo      (trgo),
    .oc_ref    (oc_ref),
    .cnt       (cnt),
    .arr       (r_q.arr),
    .cmp0      (r_q.cmp[0]),
    .cmp1      (r_q.cmp[1]),
    .mm        (r_q.ctl.mm),
    .slv       (r_q.ctl.slv),
    .run       (r_q.ctl.run),
    .en_eff    (en_eff),
    .sw_ug     (sw_ug),
    .slv_rst   (slv_rst),
    .trig_rise (trig_rise)
);

// File: tb/tb_tmr_trgo_gen.sv
`timescale 1ns/1ps
module tb_tmr_trgo_gen;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [1:0]       wr_addr;
    logic [CNT_W-1:0] wr_data;
    logic [2:0]       ch_in;
    logic             ext_trig;
    logic             trgo;
    logic [1:0]       oc_ref;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tmr_trgo_gen #(.CNT_W(CNT_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ch_in    (ch_in),
        .ext_trig (ext_trig),
        .trgo     (trgo),
        .oc_ref   (oc_ref)
    );

    function automatic logic [CNT_W-1:0] cw(input bit run, input int mm, input int slv,
                                            input bit txor, input bit tsrc, input bit msm,
                                            input bit cap0, input bit ug);
        logic [CNT_W-1:0] v;
        v     = '0;
        v[0]  = run;
        v[1]  = ug;
        v[4:2] = mm[2:0];
        v[5]  = txor;
        v[7:6] = slv[1:0];
        v[8]  = tsrc;
        v[9]  = msm;
        v[10] = cap0;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_hi(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (trgo) hi++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ch_in = '0; ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 trgo", trgo, 0);
        chk("R12 oc_ref", oc_ref, 0);
        step(5);
        chk("R12 idle trgo", trgo, 0);
        chk("R12 idle oc_ref", oc_ref, 0);
    endtask

    task automatic t_trig_sel();
        do_reset();
        wr(0, cw(1, 1, 2, 0, 0, 1, 0, 0));
        ch_in = 3'b001; step(1);
        chk("R1 pin0 high", trgo, 1);
        ch_in = 3'b010; step(1);
        chk("R1 pin0 low", trgo, 0);
        wr(0, cw(1, 1, 2, 1, 0, 1, 0, 0));
        step(1);
        chk("R1 xor 010", trgo, 1);
        ch_in = 3'b011; step(1);
        chk("R1 xor 011", trgo, 0);
        ch_in = 3'b111; step(1);
        chk("R1 xor 111", trgo, 1);
        wr(0, cw(1, 1, 2, 1, 1, 1, 0, 0));
        step(1);
        chk("R1 ext source low", trgo, 0);
        ext_trig = 1'b1; step(1);
        chk("R1 ext source high", trgo, 1);
    endtask

    task automatic t_enable_lag();
        do_reset();
        wr(0, cw(1, 1, 2, 0, 0, 0, 0, 0));
        ch_in = 3'b001; step(1);
        chk("R5 lag cycle1", trgo, 0);
        step(1);
        chk("R5 lag cycle2", trgo, 1);
        ch_in = 3'b000; step(1);
        chk("R5 fall cycle1", trgo, 1);
        step(1);
        chk("R5 fall cycle2", trgo, 0);
        do_reset();
        wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        wr(0, cw(1, 1, 0, 0, 0, 0, 0, 0));
        chk("R5 run lag0", trgo, 0);
        step(1);
        chk("R5 run lag1", trgo, 0);
        step(1);
        chk("R5 run lag2", trgo, 1);
    endtask

    task automatic t_update();
        int found;
        int extra;
        do_reset();
        wr(1, 4);
        wr(0, cw(0, 2, 0, 0, 0, 0, 0, 0));
        wr(0, cw(1, 2, 0, 0, 0, 0, 0, 0));
        found = 0;
        for (int i = 0; i < 20 && found == 0; i++) begin
            step(1);
            if (trgo) found = 1;
        end
        chk("R2 first update", found, 1);
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (trgo) extra++;
        end
        chk("R2 quiet between wraps", extra, 0);
        step(1);
        chk("R2 period 5", trgo, 1);
    endtask

    task automatic t_pause();
        int hi;
        do_reset();
        wr(1, 2);
        wr(0, cw(0, 2, 0, 0, 0, 0, 0, 0));
        wr(0, cw(1, 2, 2, 0, 0, 0, 0, 0));
        count_hi(12, hi);
        chk("R6 held while low", hi, 0);
        ch_in = 3'b001;
        count_hi(12, hi);
        chk("R6 runs while high", hi, 4);
    endtask

    task automatic t_sw_ug();
        int hi;
        do_reset();
        wr(1, 9);
        wr(2, 5);
        wr(0, cw(1, 0, 0, 0, 0, 0, 0, 0));
        step(8);
        wr(0, cw(1, 0, 0, 0, 0, 0, 0, 1));
        chk("R3 pulse", trgo, 1);
        chk("R3 restart ref", oc_ref[0], 1);
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (oc_ref[0]) hi++;
        end
        chk("R3 count from zero", hi, 4);
        step(1);
        chk("R3 ref drops at 5", oc_ref[0], 0);
        count_hi(20, hi);
        chk("R3 no wrap pulse", hi, 0);
    endtask

    task automatic t_slave_rst();
        do_reset();
        wr(1, 20);
        wr(0, cw(1, 0, 1, 0, 1, 0, 0, 0));
        step(7);
        wr(2, 3);
        chk("R8 above thr", oc_ref[0], 0);
        ext_trig = 1'b1; step(1);
        chk("R4 delayed cycle1", trgo, 0);
        chk("R4 counter restarted", oc_ref[0], 1);
        step(1);
        chk("R4 delayed cycle2", trgo, 1);
        step(1);
        chk("R4 single pulse", trgo, 0);
        ext_trig = 1'b0; step(1);
        wr(0, cw(1, 2, 1, 0, 1, 0, 0, 0));
        ext_trig = 1'b1; step(1);
        chk("R4 update no extra delay", trgo, 1);
        step(1);
        chk("R4 update single", trgo, 0);
    endtask

    task automatic t_start();
        do_reset();
        wr(0, cw(0, 1, 3, 0, 1, 0, 0, 0));
        ext_trig = 1'b1; step(1);
        chk("R7 start c1", trgo, 0);
        step(1);
        chk("R7 start c2", trgo, 0);
        step(1);
        chk("R7 start c3", trgo, 1);
        ext_trig = 1'b0; step(3);
        chk("R7 run stays set", trgo, 1);
    endtask

    task automatic t_compare();
        int h0, h1, mis;
        do_reset();
        wr(1, 9);
        wr(2, 3);
        wr(3, 7);
        wr(0, cw(1, 4, 0, 0, 0, 0, 0, 0));
        step(1);
        h0 = 0; h1 = 0; mis = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (oc_ref[0]) h0++;
            if (oc_ref[1]) h1++;
            if (trgo !== oc_ref[0]) mis++;
        end
        chk("R8 ch0 duty", h0, 6);
        chk("R8 ch1 duty", h1, 14);
        chk("R10 mode4 copy", mis, 0);
        wr(0, cw(1, 5, 0, 0, 0, 0, 0, 0));
        step(1);
        mis = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (trgo !== oc_ref[1]) mis++;
        end
        chk("R10 mode5 copy", mis, 0);
    endtask

    task automatic t_ccpulse();
        int hi;
        do_reset();
        wr(1, 9);
        wr(2, 3);
        wr(3, 7);
        wr(0, cw(1, 3, 0, 0, 0, 0, 0, 0));
        step(1);
        count_hi(20, hi);
        chk("R9 two matches per period", hi, 4);
        wr(0, cw(1, 3, 0, 0, 0, 0, 1, 0));
        step(1);
        count_hi(20, hi);
        chk("R9 cap0 masks match", hi, 2);
        wr(0, cw(0, 3, 0, 0, 0, 0, 1, 0));
        step(2);
        chk("R9 stopped quiet", trgo, 0);
        ch_in = 3'b001; step(1);
        chk("R9 capture pulse", trgo, 1);
        step(1);
        chk("R9 capture single", trgo, 0);
    endtask

    task automatic t_low();
        int hi;
        do_reset();
        wr(1, 3);
        wr(2, 2);
        wr(0, cw(1, 6, 0, 0, 0, 0, 0, 0));
        step(1);
        count_hi(12, hi);
        chk("R11 mode6 low", hi, 0);
        wr(0, cw(1, 7, 0, 0, 0, 0, 0, 1));
        count_hi(12, hi);
        chk("R11 mode7 low", hi, 0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_trig_sel();
        t_enable_lag();
        t_update();
        t_pause();
        t_sw_ug();
        t_slave_rst();
        t_start();
        t_compare();
        t_ccpulse();
        t_low();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule